// File: doc/BRIEF.md
# Programmable Periodic Interrupt Timer

This block raises an active-low interrupt once a chosen interval has elapsed. The interval is counted in strobes of an incoming 10 Hz tick. Software programs the timer through one register slot, address 15, on a 4-bit data bus. A write there selects one of three intervals, or none, and chooses between one-shot and repeating behaviour. A read of the same slot returns the chosen interval as a one-hot status code.

The interrupt has one way out: three reads of the timer's register. Writes do not release it. The third read returns the output to high. In repeating mode that same read also starts a fresh interval from zero. A one-shot timer goes idle after it fires and waits to be programmed again. At power-up, software writes 0 and then reads the slot three times to put the timer in a known state.

Top module: `periodic_irq_timer`

## Requirements
- R1: After synchronous reset, `irq_n` is 1, `rdata` is 0, and a read of address 15 returns status 000.
- R2: A write to address 15 decodes `wdata[2:0]` as follows: 001 selects 5 ticks, 010 selects 50 ticks and 100 selects 600 ticks. 000, and every code with more than one bit set, disables the timer.
- R3: A read of address 15 (`rd_en` high and `wr_en` low) puts the selected code on `rdata[2:0]` (001, 010, 100, or 000 when disabled) from the next clock edge. `rdata[3]` reads 0. `rdata` is 0 in every cycle that follows a cycle with no such read.
- R4: A write to address 15 restarts the count from zero. `irq_n` goes low at the clock edge that samples the Nth tick after that write, where N is the selected interval. Ticks before the write do not count.
- R5: Once low, `irq_n` stays low until the third read of address 15. The first two reads and reads at other addresses leave it low.
- R6: When `wdata[3]` was 1 on the last write (repeat mode) and the timer is enabled, the third read restarts the interval from zero. The next interrupt then follows N ticks later.
- R7: When `wdata[3]` was 0 (single mode), the timer stops after its first timeout. Further ticks and clear sequences raise no new interrupt until the next write.
- R8: The read count starts again from zero after each write to address 15 and after each timeout. It saturates at three, so a fourth read has no effect. A write leaves a pending `irq_n` low.
- R9: Writing 000 stops any count in progress. Writing 000 and then reading three times returns `irq_n` to 1 and the status to 000.
- R10: Reads and writes at any address other than 15 change neither the mode, the count, the read count nor `irq_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle strobe at 10 Hz |
| addr | input | 4 | Register address |
| wr_en | input | 1 | Write strobe, one cycle |
| rd_en | input | 1 | Read strobe, one cycle |
| wdata | input | 4 | Write data: bit 3 repeat, bits 2..0 interval code |
| rdata | output | 4 | Registered read data: status on bits 2..0 |
| irq_n | output | 1 | Active-low interrupt, registered |

## Verification
The hardest state to reach from the ports is a read count that was reset part of the way through a clear sequence. Two reads are issued first. Then either a rewrite or a timeout intervenes before the read that would otherwise have been the third. The stimulus sets this up deliberately, then checks that `irq_n` stays low through one more read and is released only by a complete new set of three reads. For the saturation case, a fourth read is placed between ticks. A wrongful restart at that read would shift the next interrupt by a measurable number of ticks.

// File: rtl/pit_pkg.sv
package pit_pkg;

  typedef enum logic [1:0] {
    IVL_OFF   = 2'd0,
    IVL_SHORT = 2'd1,
    IVL_MID   = 2'd2,
    IVL_LONG  = 2'd3
  } ivl_e;

  localparam int STAT_W  = 3;
  localparam int RPT_BIT = 3;

  // One-hot code to interval; anything that is not exactly one bit disables
  function automatic ivl_e decode_ivl(input logic [STAT_W-1:0] code);
    case (code)
      3'b001:  return IVL_SHORT;
      3'b010:  return IVL_MID;
      3'b100:  return IVL_LONG;
      default: return IVL_OFF;
    endcase
  endfunction

  function automatic logic [STAT_W-1:0] encode_ivl(input ivl_e ivl);
    case (ivl)
      IVL_SHORT: return 3'b001;
      IVL_MID:   return 3'b010;
      IVL_LONG:  return 3'b100;
      default:   return 3'b000;
    endcase
  endfunction

endpackage

// File: rtl/pit_bus_port.sv
module pit_bus_port
  import pit_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 4,
  parameter int SEL_ADDR = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wdata,
  output logic              wr_hit,
  output logic              rd_hit,
  output ivl_e              load_ivl,
  output ivl_e              cur_ivl,
  output logic              rpt,
  output logic [DATA_W-1:0] rdata
);

  localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(SEL_ADDR);
  localparam int                PAD_W   = DATA_W - STAT_W;

  logic addr_match;

  assign addr_match = (addr == MY_ADDR);
  assign wr_hit     = wr_en && addr_match;
  // a write in the same cycle takes precedence over a read
  assign rd_hit     = rd_en && !wr_en && addr_match;
  assign load_ivl   = decode_ivl(wdata[STAT_W-1:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_ivl <= IVL_OFF;
      rpt     <= 1'b0;
    end else if (wr_hit) begin
      cur_ivl <= load_ivl;
      rpt     <= wdata[RPT_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_hit) begin
      rdata <= {{PAD_W{1'b0}}, encode_ivl(cur_ivl)};
    end else begin
      rdata <= '0;
    end
  end

endmodule

// File: rtl/pit_clear_seq.sv
module pit_clear_seq #(
  parameter int CLR_READS = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic rd_hit,
  input  logic wr_hit,
  input  logic timeout,
  output logic clr_pulse
);

  localparam int CLR_W = $clog2(CLR_READS + 1);
  localparam logic [CLR_W-1:0] LAST_RD = CLR_W'(CLR_READS - 1);
  localparam logic [CLR_W-1:0] SAT_RD  = CLR_W'(CLR_READS);

  logic [CLR_W-1:0] rd_cnt;

  assign clr_pulse = rd_hit && (rd_cnt == LAST_RD);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_cnt <= '0;
    end else if (wr_hit || timeout) begin
      rd_cnt <= '0;
    end else if (rd_hit && (rd_cnt != SAT_RD)) begin
      rd_cnt <= rd_cnt + CLR_W'(1);
    end
  end

endmodule

// File: rtl/pit_interval_ctr.sv
module pit_interval_ctr
  import pit_pkg::*;
#(
  parameter int TICKS_SHORT = 5,
  parameter int TICKS_MID   = 50,
  parameter int TICKS_LONG  = 600
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic load,
  input  ivl_e load_ivl,
  input  ivl_e cur_ivl,
  input  logic restart,
  output logic timeout
);

  localparam int CNT_W = $clog2(TICKS_LONG + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;
  logic             run;
  logic             last;

  always_comb begin
    case (cur_ivl)
      IVL_SHORT: limit = CNT_W'(TICKS_SHORT);
      IVL_MID:   limit = CNT_W'(TICKS_MID);
      IVL_LONG:  limit = CNT_W'(TICKS_LONG);
      default:   limit = '0;
    endcase
  end

  assign last    = (cnt == limit - CNT_W'(1));
  assign timeout = run && tick && last && !load && !restart;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      run <= 1'b0;
    end else if (load) begin
      cnt <= '0;
      run <= (load_ivl != IVL_OFF);
    end else if (restart) begin
      cnt <= '0;
      run <= 1'b1;
    end else if (run && tick) begin
      if (last) begin
        cnt <= '0;
        run <= 1'b0;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/periodic_irq_timer.sv
module periodic_irq_timer
  import pit_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 4,
  parameter int SEL_ADDR    = 15,
  parameter int TICKS_SHORT = 5,
  parameter int TICKS_MID   = 50,
  parameter int TICKS_LONG  = 600,
  parameter int CLR_READS   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq_n
);

  logic wr_hit;
  logic rd_hit;
  logic rpt;
  logic clr_pulse;
  logic restart;
  logic timeout;
  ivl_e load_ivl;
  ivl_e cur_ivl;

  pit_bus_port #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .SEL_ADDR(SEL_ADDR)
  ) u_port (
    .clk     (clk),
    .rst     (rst),
    .addr    (addr),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .wdata   (wdata),
    .wr_hit  (wr_hit),
    .rd_hit  (rd_hit),
    .load_ivl(load_ivl),
    .cur_ivl (cur_ivl),
    .rpt     (rpt),
    .rdata   (rdata)
  );

  pit_clear_seq #(
    .CLR_READS(CLR_READS)
  ) u_clr (
    .clk      (clk),
    .rst      (rst),
    .rd_hit   (rd_hit),
    .wr_hit   (wr_hit),
    .timeout  (timeout),
    .clr_pulse(clr_pulse)
  );

  // repeat mode re-arms the interval on the completing read
  assign restart = clr_pulse && rpt && (cur_ivl != IVL_OFF);

  pit_interval_ctr #(
    .TICKS_SHORT(TICKS_SHORT),
    .TICKS_MID  (TICKS_MID),
    .TICKS_LONG (TICKS_LONG)
  ) u_ctr (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .load    (wr_hit),
    .load_ivl(load_ivl),
    .cur_ivl (cur_ivl),
    .restart (restart),
    .timeout (timeout)
  );

  // a timeout outranks a clear landing in the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_n <= 1'b1;
    end else if (timeout) begin
      irq_n <= 1'b0;
    end else if (clr_pulse) begin
      irq_n <= 1'b1;
    end
  end

endmodule

// File: rtl/pit_irq_checker.sv
module pit_irq_checker #(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 4,
  parameter int SEL_ADDR = 15
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic              rd_en,
  input logic [DATA_W-1:0] rdata,
  input logic              irq_n,
  input logic              clr_pulse
);

  logic slot_read;
  assign slot_read = rd_en && !wr_en && (addr == ADDR_W'(SEL_ADDR));

  a_r1_reset_values: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (irq_n && (rdata == '0)));

  a_r3_idle_rdata: assert property (@(posedge clk) disable iff (rst)
    !slot_read |=> (rdata == '0));

  a_r3_status_shape: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rdata[2:0]) && (rdata[DATA_W-1:3] == '0));

  a_r4_fall_on_tick: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_n) |-> $past(tick));

  a_r5_low_holds: assert property (@(posedge clk) disable iff (rst)
    (!irq_n && !clr_pulse) |=> !irq_n);

  a_r5_rise_by_read: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_n) |-> $past(slot_read));

endmodule

bind periodic_irq_timer pit_irq_checker #(
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .SEL_ADDR(SEL_ADDR)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .tick     (tick),
  .addr     (addr),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .rdata    (rdata),
  .irq_n    (irq_n),
  .clr_pulse(clr_pulse)
);

// File: tb/tb_periodic_irq_timer.sv
module tb_periodic_irq_timer;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic [3:0] addr = '0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [3:0] wdata = '0;
  logic [3:0] rdata;
  logic       irq_n;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  periodic_irq_timer dut (
    .clk(clk), .rst(rst), .tick(tick), .addr(addr), .wr_en(wr_en),
    .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .irq_n(irq_n)
  );

  // ---------------- behavioural reference ----------------
  int         m_ivl, m_cnt, m_rd;
  bit         m_rpt, m_run, m_irq;
  logic [3:0] m_rdata;

  function automatic int lim(input int i);
    case (i) 1: return 5; 2: return 50; 3: return 600; default: return 0; endcase
  endfunction
  function automatic int dec(input logic [2:0] c);
    if (c == 3'b001) return 1;
    if (c == 3'b010) return 2;
    if (c == 3'b100) return 3;
    return 0;
  endfunction
  function automatic logic [3:0] enc(input int i);
    case (i) 1: return 4'b0001; 2: return 4'b0010; 3: return 4'b0100; default: return 4'b0000; endcase
  endfunction

  always @(posedge clk) begin
    bit w, r, clr, rs, to;
    if (rst) begin
      m_ivl = 0; m_cnt = 0; m_rd = 0; m_rpt = 0; m_run = 0; m_irq = 0; m_rdata = '0;
    end else begin
      w   = wr_en && addr == 4'd15;
      r   = rd_en && !wr_en && addr == 4'd15;
      clr = r && m_rd == 2;
      rs  = clr && m_rpt && m_ivl != 0;
      to  = m_run && tick && (m_cnt == lim(m_ivl) - 1) && !rs && !w;
      m_rdata = r ? enc(m_ivl) : 4'b0000;
      if (w || to) m_rd = 0;
      else if (r && m_rd < 3) m_rd++;
      if (to) m_irq = 1;
      else if (clr) m_irq = 0;
      if (w) begin
        m_ivl = dec(wdata[2:0]); m_rpt = wdata[3]; m_cnt = 0; m_run = (m_ivl != 0);
      end else if (rs) begin
        m_cnt = 0; m_run = 1;
      end else if (m_run && tick) begin
        if (to) begin m_cnt = 0; m_run = 0; end
        else m_cnt++;
      end
    end
  end

  // compare with the reference away from the active edge, every clock
  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (irq_n !== !m_irq) begin
        failures++;
        $display("FAIL R4 model irq_n actual=%0b expected=%0b t=%0t", irq_n, !m_irq, $time);
      end
      checks++;
      if (rdata !== m_rdata) begin
        failures++;
        $display("FAIL R3 model rdata actual=%0h expected=%0h t=%0t", rdata, m_rdata, $time);
      end
    end
  end

  // ---------------- directed stimulus ----------------
  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic w, input logic r, input logic [3:0] a,
                      input logic [3:0] d, input logic t);
    wr_en = w; rd_en = r; addr = a; wdata = d; tick = t;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0; tick = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic wr15(input logic [3:0] d); step(1'b1, 1'b0, 4'd15, d, 1'b0); endtask
  task automatic rd15();                    step(1'b0, 1'b1, 4'd15, 4'd0, 1'b0); endtask
  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 4'd0, 4'd0, 1'b1);
  endtask
  task automatic irq_is(input string req, input logic exp);
    chk(req, {3'b000, irq_n}, {3'b000, exp});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 reset irq_n", {3'b000, irq_n}, 4'd1);
    chk("R1 reset rdata", rdata, 4'd0);
    rd15(); chk("R1 reset status", rdata, 4'b0000);

    // single 0.5 s
    wr15(4'b0001); rd15(); chk("R3 status short", rdata, 4'b0001);
    ticks(4); irq_is("R4 before 5th tick", 1'b1);
    ticks(1); irq_is("R4 at 5th tick", 1'b0);
    rd15(); rd15(); irq_is("R5 after two reads", 1'b0);
    step(1'b0, 1'b1, 4'd3, 4'd0, 1'b0); irq_is("R10 other-address read", 1'b0);
    rd15(); irq_is("R5 third read clears", 1'b1);
    ticks(20); irq_is("R7 single stays idle", 1'b1);
    rd15(); rd15(); rd15(); ticks(10); irq_is("R7 no rearm in single", 1'b1);

    // repeat 5 s
    wr15(4'b1010); rd15(); chk("R3 status mid", rdata, 4'b0010);
    ticks(49); irq_is("R2 mid before 50", 1'b1);
    ticks(1);  irq_is("R2 mid at 50", 1'b0);
    rd15(); rd15(); rd15(); irq_is("R6 cleared", 1'b1);
    ticks(49); irq_is("R6 restart before 50", 1'b1);
    ticks(1);  irq_is("R6 restart at 50", 1'b0);
    rd15(); rd15(); rd15(); irq_is("R6 cleared again", 1'b1);

    // read count reset by a write
    wr15(4'b0001); ticks(5); irq_is("R4 short timeout", 1'b0);
    rd15(); rd15(); wr15(4'b0001); irq_is("R8 write keeps irq", 1'b0);
    rd15(); rd15(); irq_is("R8 count reset by write", 1'b0);
    rd15(); irq_is("R8 third read after write", 1'b1);
    ticks(5); irq_is("R4 rewrite timeout", 1'b0);

    // read count reset by a timeout, then saturation
    wr15(4'b1001); rd15(); rd15(); ticks(5); irq_is("R8 pending", 1'b0);
    rd15(); irq_is("R8 count reset by timeout", 1'b0);
    rd15(); rd15(); irq_is("R8 full clear", 1'b1);
    ticks(2); rd15(); ticks(2); irq_is("R8 fourth read no restart", 1'b1);
    ticks(1); irq_is("R8 saturated timing", 1'b0);

    // initialisation sequence
    wr15(4'b0000); irq_is("R9 write zero keeps irq", 1'b0);
    rd15(); rd15(); rd15(); irq_is("R9 init clears", 1'b1);
    rd15(); chk("R9 status after init", rdata, 4'b0000);

    // illegal code disables
    wr15(4'b0011); rd15(); chk("R2 illegal code status", rdata, 4'b0000);
    ticks(700); irq_is("R2 illegal code silent", 1'b1);

    // long interval
    wr15(4'b0100); rd15(); chk("R3 status long", rdata, 4'b0100);
    ticks(599); irq_is("R2 long before 600", 1'b1);
    ticks(1);   irq_is("R2 long at 600", 1'b0);
    rd15(); rd15(); rd15(); irq_is("R5 long cleared", 1'b1);

    // stop by writing zero mid-count
    wr15(4'b0001); ticks(3); wr15(4'b0000); ticks(10); irq_is("R9 stopped", 1'b1);

    // write at another address
    step(1'b1, 1'b0, 4'd14, 4'b0001, 1'b0); rd15(); chk("R10 other write status", rdata, 4'b0000);
    ticks(10); irq_is("R10 other write no timer", 1'b1);

    // earlier ticks do not count after a rewrite
    wr15(4'b0001); ticks(3); wr15(4'b0001); ticks(4); irq_is("R4 count from zero", 1'b1);
    ticks(1); irq_is("R4 restarted interval", 1'b0);
    rd15(); rd15(); rd15(); irq_is("R5 final clear", 1'b1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule